// File: doc/BRIEF.md
# Oblivious Subtree Command Engine

This block sits on a memory buffer device and owns one half of a tree-shaped oblivious memory. Each half holds its own bucket array, stash and position map. The host addresses the engine over a small command port. Each accepted command gets a one-cycle response on the following clock.

An access command runs a complete path access inside the engine without further host help. The engine reads every bucket on the block's root-to-leaf path into the stash, pulls the requested block out (updating it on a write) and writes the path back, deepest level first. The host polls with probe, then reads the block with fetch. The engine never chooses leaves. The host picks a fresh leaf and broadcasts an append carrying the block. Only the engine whose half contains that leaf takes the block into its stash.

Every access costs the same number of cycles and touches the same number of slots, whether the block is present or not. Empty slots are read and rewritten like full ones.

Top module: `osub_engine`

## Requirements
- R1: `cmd_ready` is always high. Every cycle with `cmd_valid` high produces exactly one `rsp_valid` pulse on the next cycle, and a cycle without a command produces none.
- R2: Command codes on `cmd_op` are 0 access, 1 probe, 2 fetch and 3 append. Response codes on `rsp_code` are 0 acknowledge, 1 busy, 2 done and 3 error.
- R3: A probe answers busy while an access is in progress and done otherwise.
- R4: Any command other than probe that arrives during an access is answered with error and has no effect. The access keeps its timing, the result register is unchanged, and a rejected append inserts nothing.
- R5: An idle engine acknowledges an access. Probes issued on each of the next 2*LEVELS*SLOTS+1 = 33 cycles answer busy, and the probe one cycle later answers done. This holds whether or not the block is present.
- R6: A fetch on an idle engine answers acknowledge, and `rsp_data` carries the last access result. That result is the write data for a write, otherwise the stored value, or zero if the block is absent. `rsp_data` is zero on every non-fetch response.
- R7: An append is absorbed only when `cmd_leaf[LEVELS-1]` equals the engine's subtree number. The lower LEVELS-1 bits are the leaf inside the subtree. An append for the other subtree is acknowledged and ignored.
- R8: An absorbed block survives later accesses to other blocks, including write-back into shallow and deep buckets, and is returned by a later access to its address. An accessed block leaves the engine, so a second access without a new append returns zero.
- R9: `stash_overflow` rises when a block must enter a stash whose 16 entries are all valid. It then stays high until reset.
- R10: After reset `rsp_valid` and `stash_overflow` are low, a probe answers done, and a fetch returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_ready | output | 1 | Always high; engine takes a command every cycle |
| cmd_op | input | 2 | Command code |
| cmd_addr | input | ADDR_W (5) | Block address |
| cmd_write | input | 1 | Access is a write |
| cmd_wdata | input | DATA_W (32) | Write data (access) or block data (append) |
| cmd_leaf | input | LEVELS (4) | New leaf for append; top bit selects subtree |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | Response code |
| rsp_data | output | DATA_W (32) | Fetched block data, zero otherwise |
| stash_overflow | output | 1 | Sticky stash overflow flag |

## Verification
Properties check on every cycle the one-response-per-command rule, the busy/done and error answers chosen from the engine's activity, the zero data outside fetches, and that the overflow flag never drops outside reset. Only the bench's scenarios can show the data path. That covers blocks moving between stash and tree across several accesses, deep and shallow placement on write-back, filtering of appends by subtree, removal of an accessed block, and the fixed 33-cycle busy window with and without rejected commands in it.

// File: rtl/osub_pkg.sv
package osub_pkg;
    localparam int LEVELS     = 4;
    localparam int SLOTS      = 4;
    localparam int DATA_W     = 32;
    localparam int STASH_N    = 16;
    localparam int ADDR_W     = 5;
    localparam int ADDR_SPACE = 1 << ADDR_W;
    localparam int LLEAF_W    = LEVELS - 1;
    localparam int GLEAF_W    = LEVELS;
    localparam int NBUCKET    = (1 << LEVELS) - 1;
    localparam int NSLOT      = NBUCKET * SLOTS;
    localparam int STEPS      = LEVELS * SLOTS;
    localparam int STEP_W     = $clog2(STEPS);
    localparam int SIDX_W     = $clog2(NSLOT);
    localparam int STIDX_W    = $clog2(STASH_N);
    localparam int LVL_W      = $clog2(LEVELS);
    localparam int SLOT_W     = $clog2(SLOTS);

    typedef struct packed {
        logic               vld;
        logic [ADDR_W-1:0]  addr;
        logic [LLEAF_W-1:0] leaf;
        logic [DATA_W-1:0]  data;
    } blk_t;

    typedef enum logic [1:0] {
        OP_ACCESS = 2'd0,
        OP_PROBE  = 2'd1,
        OP_FETCH  = 2'd2,
        OP_APPEND = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        RSP_ACK  = 2'd0,
        RSP_BUSY = 2'd1,
        RSP_DONE = 2'd2,
        RSP_ERR  = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_READ,
        ST_SELECT,
        ST_WRITE
    } st_e;

    // Flat slot number of slot z in the bucket at level lvl on the path to leaf.
    function automatic logic [SIDX_W-1:0] slot_index(input logic [LLEAF_W-1:0] leaf,
                                                     input logic [LVL_W-1:0]   lvl,
                                                     input logic [SLOT_W-1:0]  z);
        int l;
        int b;
        l = int'(lvl);
        b = (1 << l) - 1 + int'(leaf >> (LLEAF_W - l));
        return SIDX_W'(b * SLOTS + int'(z));
    endfunction

    // True when the path to leaf a passes through the level-l bucket of path b.
    function automatic logic on_path(input logic [LLEAF_W-1:0] a,
                                     input logic [LLEAF_W-1:0] b,
                                     input int l);
        return (a >> (LLEAF_W - l)) == (b >> (LLEAF_W - l));
    endfunction

    function automatic logic [STIDX_W-1:0] first_one(input logic [STASH_N-1:0] v);
        logic [STIDX_W-1:0] r;
        r = '0;
        for (int i = STASH_N - 1; i >= 0; i--) begin
            if (v[i]) r = STIDX_W'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/osub_tree.sv
module osub_tree
    import osub_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [SIDX_W-1:0] rd_idx,
    output blk_t              rd_blk,
    input  logic              wr_en,
    input  logic [SIDX_W-1:0] wr_idx,
    input  blk_t              wr_blk
);
    blk_t mem [NSLOT];

    assign rd_blk = mem[rd_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NSLOT; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_idx] <= wr_blk;
        end
    end
endmodule

// File: rtl/osub_stash.sv
module osub_stash
    import osub_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               ins_en,
    input  blk_t               ins_blk,
    output logic               ins_full,
    input  logic [ADDR_W-1:0]  find_addr,
    output logic               find_hit,
    output logic [STIDX_W-1:0] find_idx,
    output blk_t               find_blk,
    input  logic [LLEAF_W-1:0] ev_path,
    input  logic [LVL_W-1:0]   ev_lvl,
    output logic               ev_hit,
    output logic [STIDX_W-1:0] ev_idx,
    output blk_t               ev_blk,
    input  logic               rm_en,
    input  logic [STIDX_W-1:0] rm_idx
);
    blk_t ent [STASH_N];
    logic [STASH_N-1:0] free_v, find_v, ev_v;

    for (genvar g = 0; g < STASH_N; g++) begin : g_match
        assign free_v[g] = !ent[g].vld;
        assign find_v[g] = ent[g].vld && (ent[g].addr == find_addr);
        assign ev_v[g]   = ent[g].vld && on_path(ent[g].leaf, ev_path, int'(ev_lvl));
    end

    assign ins_full = ~|free_v;
    assign find_hit = |find_v;
    assign find_idx = first_one(find_v);
    assign find_blk = ent[find_idx];
    assign ev_hit   = |ev_v;
    assign ev_idx   = first_one(ev_v);
    assign ev_blk   = ent[ev_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STASH_N; i++) ent[i] <= '0;
        end else begin
            if (ins_en && !ins_full) ent[first_one(free_v)] <= ins_blk;
            if (rm_en) ent[rm_idx].vld <= 1'b0;
        end
    end
endmodule

// File: rtl/osub_posmap.sv
module osub_posmap
    import osub_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic               wr_vld,
    input  logic [LLEAF_W-1:0] wr_leaf,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic               rd_vld,
    output logic [LLEAF_W-1:0] rd_leaf
);
    logic [ADDR_SPACE-1:0] vld_q;
    logic [LLEAF_W-1:0]    leaf_q [ADDR_SPACE];

    assign rd_vld  = vld_q[rd_addr];
    assign rd_leaf = leaf_q[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= '0;
            for (int i = 0; i < ADDR_SPACE; i++) leaf_q[i] <= '0;
        end else if (wr_en) begin
            vld_q[wr_addr]  <= wr_vld;
            leaf_q[wr_addr] <= wr_leaf;
        end
    end
endmodule

// File: rtl/osub_engine.sv
module osub_engine
    import osub_pkg::*;
#(
    parameter bit SUB_ID = 1'b0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_valid,
    output logic               cmd_ready,
    input  logic [1:0]         cmd_op,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic               cmd_write,
    input  logic [DATA_W-1:0]  cmd_wdata,
    input  logic [GLEAF_W-1:0] cmd_leaf,
    output logic               rsp_valid,
    output logic [1:0]         rsp_code,
    output logic [DATA_W-1:0]  rsp_data,
    output logic               stash_overflow
);
    st_e                state;
    logic [STEP_W-1:0]  step;
    logic [LLEAF_W-1:0] path;
    logic [ADDR_W-1:0]  tgt_addr;
    logic               tgt_write;
    logic [DATA_W-1:0]  tgt_wdata;
    logic [DATA_W-1:0]  res_data;
    logic               ovf_q;
    rsp_e               rsp_q;
    logic               busy;
    op_e                op;

    logic [LVL_W-1:0]   lvl_step, lvl_cur;
    logic [SLOT_W-1:0]  slot_z;
    logic [SIDX_W-1:0]  slot;
    blk_t               tree_rd, tree_wr, app_blk, ins_blk;
    logic               tree_we;
    logic               append_ok, ins_en, ins_full;
    logic               find_hit, ev_hit, rm_en;
    logic [STIDX_W-1:0] find_idx, ev_idx, rm_idx;
    blk_t               find_blk, ev_blk;
    logic               pm_we, pm_wvld, pm_vld;
    logic [ADDR_W-1:0]  pm_waddr;
    logic [LLEAF_W-1:0] pm_leaf;

    assign cmd_ready      = 1'b1;
    assign busy           = (state != ST_IDLE);
    assign op             = op_e'(cmd_op);
    assign rsp_code       = rsp_q;
    assign stash_overflow = ovf_q;

    // Read walks root to leaf; write-back walks leaf to root.
    assign lvl_step = LVL_W'(step >> SLOT_W);
    assign lvl_cur  = (state == ST_WRITE) ? (LVL_W'(LEVELS - 1) - lvl_step) : lvl_step;
    assign slot_z   = step[SLOT_W-1:0];
    assign slot     = slot_index(path, lvl_cur, slot_z);

    assign append_ok = cmd_valid && !busy && (op == OP_APPEND)
                       && (cmd_leaf[GLEAF_W-1] == SUB_ID);

    always_comb begin
        app_blk.vld  = 1'b1;
        app_blk.addr = cmd_addr;
        app_blk.leaf = cmd_leaf[LLEAF_W-1:0];
        app_blk.data = cmd_wdata;
    end

    assign ins_en  = ((state == ST_READ) && tree_rd.vld) || append_ok;
    assign ins_blk = (state == ST_READ) ? tree_rd : app_blk;

    assign rm_en  = ((state == ST_SELECT) && find_hit) || ((state == ST_WRITE) && ev_hit);
    assign rm_idx = (state == ST_SELECT) ? find_idx : ev_idx;

    // Every slot on the path is rewritten: emptied on read, refilled or left dummy on write.
    assign tree_we = (state == ST_READ) || (state == ST_WRITE);
    assign tree_wr = ((state == ST_WRITE) && ev_hit) ? ev_blk : '0;

    assign pm_we    = (append_ok && !ins_full) || (state == ST_SELECT);
    assign pm_waddr = (state == ST_SELECT) ? tgt_addr : cmd_addr;
    assign pm_wvld  = (state != ST_SELECT);

    osub_tree u_tree (
        .clk    (clk),
        .rst    (rst),
        .rd_idx (slot),
        .rd_blk (tree_rd),
        .wr_en  (tree_we),
        .wr_idx (slot),
        .wr_blk (tree_wr)
    );

    osub_stash u_stash (
        .clk       (clk),
        .rst       (rst),
        .ins_en    (ins_en),
        .ins_blk   (ins_blk),
        .ins_full  (ins_full),
        .find_addr (tgt_addr),
        .find_hit  (find_hit),
        .find_idx  (find_idx),
        .find_blk  (find_blk),
        .ev_path   (path),
        .ev_lvl    (lvl_cur),
        .ev_hit    (ev_hit),
        .ev_idx    (ev_idx),
        .ev_blk    (ev_blk),
        .rm_en     (rm_en),
        .rm_idx    (rm_idx)
    );

    osub_posmap u_posmap (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (pm_we),
        .wr_addr (pm_waddr),
        .wr_vld  (pm_wvld),
        .wr_leaf (cmd_leaf[LLEAF_W-1:0]),
        .rd_addr (cmd_addr),
        .rd_vld  (pm_vld),
        .rd_leaf (pm_leaf)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            step      <= '0;
            path      <= '0;
            tgt_addr  <= '0;
            tgt_write <= 1'b0;
            tgt_wdata <= '0;
            res_data  <= '0;
            ovf_q     <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_q     <= RSP_ACK;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= cmd_valid;
            rsp_data  <= '0;
            if (cmd_valid) begin
                if (busy) begin
                    rsp_q <= (op == OP_PROBE) ? RSP_BUSY : RSP_ERR;
                end else begin
                    case (op)
                        OP_ACCESS: begin
                            rsp_q     <= RSP_ACK;
                            state     <= ST_READ;
                            step      <= '0;
                            path      <= pm_vld ? pm_leaf : '0;
                            tgt_addr  <= cmd_addr;
                            tgt_write <= cmd_write;
                            tgt_wdata <= cmd_wdata;
                        end
                        OP_PROBE:  rsp_q <= RSP_DONE;
                        OP_FETCH: begin
                            rsp_q    <= RSP_ACK;
                            rsp_data <= res_data;
                        end
                        OP_APPEND: rsp_q <= RSP_ACK;
                        default:   rsp_q <= RSP_ERR;
                    endcase
                end
            end

            if (ins_en && ins_full) ovf_q <= 1'b1;

            case (state)
                ST_READ: begin
                    step <= step + 1'b1;
                    if (step == STEP_W'(STEPS - 1)) state <= ST_SELECT;
                end
                ST_SELECT: begin
                    if (tgt_write)     res_data <= tgt_wdata;
                    else if (find_hit) res_data <= find_blk.data;
                    else               res_data <= '0;
                    step  <= '0;
                    state <= ST_WRITE;
                end
                ST_WRITE: begin
                    step <= step + 1'b1;
                    if (step == STEP_W'(STEPS - 1)) state <= ST_IDLE;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/osub_chk.sv
module osub_chk
    import osub_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic [1:0]        cmd_op,
    input logic              busy,
    input logic              rsp_valid,
    input logic [1:0]        rsp_code,
    input logic [DATA_W-1:0] rsp_data,
    input logic              stash_overflow
);
    p_rsp_follows_cmd_r1: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> rsp_valid);

    p_no_spurious_rsp_r1: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> !rsp_valid);

    p_probe_busy_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_PROBE && busy) |=> (rsp_code == RSP_BUSY));

    p_probe_done_r3: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == OP_PROBE && !busy) |=> (rsp_code == RSP_DONE));

    p_reject_busy_r4: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op != OP_PROBE && busy) |=> (rsp_code == RSP_ERR));

    p_data_fetch_only_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op != OP_FETCH) |=> (rsp_data == '0));

    p_overflow_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        stash_overflow |=> stash_overflow);
endmodule

bind osub_engine osub_chk u_chk (
    .clk            (clk),
    .rst            (rst),
    .cmd_valid      (cmd_valid),
    .cmd_op         (cmd_op),
    .busy           (busy),
    .rsp_valid      (rsp_valid),
    .rsp_code       (rsp_code),
    .rsp_data       (rsp_data),
    .stash_overflow (stash_overflow)
);

// File: tb/osub_engine_tb.sv
module osub_engine_tb;
    import osub_pkg::*;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               cmd_valid = 1'b0;
    logic               cmd_ready;
    logic [1:0]         cmd_op = '0;
    logic [ADDR_W-1:0]  cmd_addr = '0;
    logic               cmd_write = 1'b0;
    logic [DATA_W-1:0]  cmd_wdata = '0;
    logic [GLEAF_W-1:0] cmd_leaf = '0;
    logic               rsp_valid;
    logic [1:0]         rsp_code;
    logic [DATA_W-1:0]  rsp_data;
    logic               stash_overflow;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;
    logic              r_valid;
    logic [1:0]        r_code;
    logic [DATA_W-1:0] r_data;

    localparam int BUSY_WIN = 2 * LEVELS * SLOTS + 1;

    always #5 clk = ~clk;

    osub_engine u_dut (
        .clk            (clk),
        .rst            (rst),
        .cmd_valid      (cmd_valid),
        .cmd_ready      (cmd_ready),
        .cmd_op         (cmd_op),
        .cmd_addr       (cmd_addr),
        .cmd_write      (cmd_write),
        .cmd_wdata      (cmd_wdata),
        .cmd_leaf       (cmd_leaf),
        .rsp_valid      (rsp_valid),
        .rsp_code       (rsp_code),
        .rsp_data       (rsp_data),
        .stash_overflow (stash_overflow)
    );

    typedef struct packed {
        logic [1:0]         op;
        logic [ADDR_W-1:0]  addr;
        logic               wr;
        logic [DATA_W-1:0]  wdata;
        logic [GLEAF_W-1:0] leaf;
        logic [1:0]         code;
        logic [DATA_W-1:0]  data;
        logic               poll;
    } vec_t;

    // R2 encodings: op 0 access, 1 probe, 2 fetch, 3 append; rsp 0 ack, 1 busy, 2 done, 3 error.
    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{2'd3, 5'd3, 1'b0, 32'h1111_0003, 4'b0010, 2'd0, 32'h0,          1'b0}, // R7 own half
        '{2'd3, 5'd7, 1'b0, 32'h2222_0007, 4'b0101, 2'd0, 32'h0,          1'b0},
        '{2'd3, 5'd8, 1'b0, 32'hDEAD_0008, 4'b1001, 2'd0, 32'h0,          1'b0}, // R7 other half
        '{2'd0, 5'd3, 1'b0, 32'h0,         4'b0000, 2'd0, 32'h0,          1'b1}, // R5
        '{2'd2, 5'd0, 1'b0, 32'h0,         4'b0000, 2'd0, 32'h1111_0003, 1'b0}, // R6 read
        '{2'd0, 5'd7, 1'b1, 32'hCAFE_0007, 4'b0000, 2'd0, 32'h0,          1'b1},
        '{2'd2, 5'd0, 1'b0, 32'h0,         4'b0000, 2'd0, 32'hCAFE_0007, 1'b0}, // R6 write
        '{2'd0, 5'd8, 1'b0, 32'h0,         4'b0000, 2'd0, 32'h0,          1'b1},
        '{2'd2, 5'd0, 1'b0, 32'h0,         4'b0000, 2'd0, 32'h0,          1'b0}, // R7 ignored
        '{2'd0, 5'd3, 1'b0, 32'h0,         4'b0000, 2'd0, 32'h0,          1'b1},
        '{2'd2, 5'd0, 1'b0, 32'h0,         4'b0000, 2'd0, 32'h0,          1'b0}, // R8 removed
        '{2'd1, 5'd0, 1'b0, 32'h0,         4'b0000, 2'd2, 32'h0,          1'b0}  // R3 idle
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Called at a falling edge; the response is captured one falling edge later.
    task automatic do_cmd(input logic [1:0] op, input logic [ADDR_W-1:0] addr, input logic wr,
                          input logic [DATA_W-1:0] wdata, input logic [GLEAF_W-1:0] leaf);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_addr  = addr;
        cmd_write = wr;
        cmd_wdata = wdata;
        cmd_leaf  = leaf;
        @(negedge clk);
        r_valid = rsp_valid;
        r_code  = rsp_code;
        r_data  = rsp_data;
    endtask

    task automatic idle_cycle();
        cmd_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic poll(output int nb);
        bit fin;
        nb  = 0;
        fin = 1'b0;
        while (!fin) begin
            do_cmd(2'd1, '0, 1'b0, '0, '0);
            if (r_code != 2'd1 || nb > 200) fin = 1'b1;
            else nb++;
        end
    endtask

    task automatic access_fetch(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp,
                                input string req);
        int nb;
        do_cmd(2'd0, a, 1'b0, '0, '0);
        poll(nb);
        do_cmd(2'd2, '0, 1'b0, '0, '0);
        chk(r_code == 2'd0 && r_data == exp, req, "fetched data", r_data, exp);
    endtask

    task automatic do_reset();
        cmd_valid = 1'b0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int nb;
        do_reset();
        // R10 reset state
        chk(rsp_valid == 1'b0, "R10", "rsp_valid after reset", 32'(rsp_valid), 0);
        chk(stash_overflow == 1'b0, "R10", "overflow after reset", 32'(stash_overflow), 0);
        chk(cmd_ready == 1'b1, "R1", "cmd_ready", 32'(cmd_ready), 1);
        do_cmd(2'd1, '0, 1'b0, '0, '0);
        chk(r_valid && r_code == 2'd2, "R10", "probe after reset", 32'(r_code), 2);
        do_cmd(2'd2, '0, 1'b0, '0, '0);
        chk(r_code == 2'd0 && r_data == '0, "R10", "fetch after reset", r_data, 0);
        idle_cycle();
        chk(rsp_valid == 1'b0, "R1", "no response without command", 32'(rsp_valid), 0);

        for (int i = 0; i < NV; i++) begin
            do_cmd(VEC[i].op, VEC[i].addr, VEC[i].wr, VEC[i].wdata, VEC[i].leaf);
            chk(r_valid == 1'b1, "R1", $sformatf("vector %0d valid", i), 32'(r_valid), 1);
            chk(r_code == VEC[i].code, "R2", $sformatf("vector %0d code", i),
                32'(r_code), 32'(VEC[i].code));
            chk(r_data == VEC[i].data, "R6", $sformatf("vector %0d data", i), r_data, VEC[i].data);
            if (VEC[i].poll) begin
                poll(nb);
                chk(nb == BUSY_WIN, "R5", $sformatf("vector %0d busy cycles", i),
                    32'(nb), 32'(BUSY_WIN));
                chk(r_code == 2'd2, "R3", "probe after access", 32'(r_code), 2);
            end
        end

        // R4: commands during an access are rejected and change nothing
        do_cmd(2'd0, 5'd12, 1'b0, '0, '0);
        do_cmd(2'd3, 5'd20, 1'b0, 32'h0000_0055, 4'b0011);
        chk(r_code == 2'd3, "R4", "append while busy", 32'(r_code), 3);
        do_cmd(2'd2, '0, 1'b0, '0, '0);
        chk(r_code == 2'd3 && r_data == '0, "R4", "fetch while busy", 32'(r_code), 3);
        do_cmd(2'd0, 5'd3, 1'b1, 32'h0000_0077, '0);
        chk(r_code == 2'd3, "R4", "access while busy", 32'(r_code), 3);
        poll(nb);
        chk(nb == BUSY_WIN - 3, "R4", "busy window kept", 32'(nb), 32'(BUSY_WIN - 3));
        access_fetch(5'd20, 32'h0, "R4");

        // R8: blocks written back at root and at a deep level come back later
        do_cmd(2'd3, 5'd5,  1'b0, 32'hA5A5_0005, 4'b0011);
        do_cmd(2'd3, 5'd9,  1'b0, 32'hB9B9_0009, 4'b0110);
        do_cmd(2'd3, 5'd10, 1'b0, 32'hC1C1_000A, 4'b0111);
        access_fetch(5'd9,  32'hB9B9_0009, "R8");
        access_fetch(5'd10, 32'hC1C1_000A, "R8");
        access_fetch(5'd5,  32'hA5A5_0005, "R8");
        access_fetch(5'd5,  32'h0,         "R8");

        // R9: overflow on the seventeenth block, sticky until reset
        idle_cycle();
        do_reset();
        for (int i = 0; i < STASH_N; i++)
            do_cmd(2'd3, ADDR_W'(i), 1'b0, 32'(i), {1'b0, LLEAF_W'(i)});
        chk(stash_overflow == 1'b0, "R9", "sixteen blocks fit", 32'(stash_overflow), 0);
        do_cmd(2'd3, ADDR_W'(STASH_N), 1'b0, 32'h0000_0099, 4'b0001);
        chk(stash_overflow == 1'b1, "R9", "overflow raised", 32'(stash_overflow), 1);
        do_cmd(2'd1, '0, 1'b0, '0, '0);
        idle_cycle();
        chk(stash_overflow == 1'b1, "R9", "overflow sticky", 32'(stash_overflow), 1);
        do_reset();
        chk(stash_overflow == 1'b0, "R9", "overflow cleared by reset", 32'(stash_overflow), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule